// File: doc/BRIEF.md
# Host-to-device address translator

This block sits on the memory side of an endpoint device and turns a host physical address into a device physical address. It holds no registers of its own: four decoder configurations are presented on its inputs. Each configuration has a base, a size, a skip amount, a granularity encoding, a ways encoding and a committed flag. On each request strobe the block walks the decoders from index 0 upward and keeps a running device-address base as it goes. One cycle later it returns the translated address together with a hit or miss indication.

Device memory is packed across decoders. Every decoder the walk reaches adds its skip to the running base. Every decoder that the walk passes over without a match also adds its per-device share, which is its size divided by its interleave ways. Inside the matching decoder, the interleave selector bits sit just above the granularity bits. These bits are cut out of the offset, and the bits above them move down to close the gap.

Top module: `hpa_dpa_xlate`

## Requirements
- R1: `vld_o` is high in exactly the cycle after a cycle with `req_i` high, and is low otherwise. After reset `vld_o`, `hit_o` and `dpa_o` are all zero.
- R2: Bits 27:0 of each decoder's base, size and skip inputs are ignored. Only bits from 28 upward take part.
- R3: Decoders are visited in index order starting at 0, and the first matching decoder ends the walk. Decoders with a higher index than the matching one have no effect, even if they overlap it or are uncommitted.
- R4: The running base starts at zero. Each visited decoder adds its skip before it is tested. Each visited decoder that does not match also adds its size shifted right by its ways encoding.
- R5: If the walk reaches a decoder whose committed flag is 0, the result is a miss. This holds even when a later decoder would match.
- R6: A decoder matches when the address is at least its base and the address minus the base is less than its size. The address base+size is outside the decoder and base+size-1 is inside.
- R7: For a match with granularity encoding g and ways encoding w, let off be the address minus the base. Bits 7+g..0 of off stay in place. Bits from 8+g+w upward are shifted right by w. Bits 8+g to 7+g+w are dropped. The result is the two parts ORed together, plus the running base.
- R8: A ways encoding w from 0 to 4 means 2^w ways. When the walk reaches a decoder with any larger encoding, the result is a miss.
- R9: If no decoder matches, the result is a miss. On every miss `hit_o` is 0 and `dpa_o` is 0.
- R10: In cycles without a request, `hit_o` and `dpa_o` keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request strobe |
| hpa_i | input | ADDR_W | Host physical address |
| dec_base_i | input | NUM_DEC x ADDR_W | Per-decoder base |
| dec_size_i | input | NUM_DEC x ADDR_W | Per-decoder size |
| dec_skip_i | input | NUM_DEC x ADDR_W | Per-decoder skip amount |
| dec_ig_i | input | NUM_DEC x IG_W | Per-decoder granularity encoding (256 bytes << g) |
| dec_iw_i | input | NUM_DEC x IW_W | Per-decoder ways encoding |
| dec_commit_i | input | NUM_DEC | Per-decoder committed flag |
| vld_o | output | 1 | Result valid, one cycle after `req_i` |
| hit_o | output | 1 | 1 on a translation hit, 0 on a miss |
| dpa_o | output | ADDR_W | Device physical address, zero on a miss |

## Verification
On every cycle, the assertions check the following:
- the one-cycle timing of `vld_o`;
- that outputs are held between requests;
- that a miss always returns address zero;
- that an uncommitted decoder 0, or a bad ways encoding on decoder 0, can never produce a hit.

Only the bench's scenarios can show that the arithmetic is correct. This covers skip and share accumulation across several decoders, the cut of the interleave bits for each granularity and ways pair, the boundary addresses at base-1, base+size-1 and base+size, masking of the low configuration bits, and the precedence of the first match over overlapping or broken later decoders.

// File: rtl/hpa_dpa_xlate_pkg.sv
package hpa_dpa_xlate_pkg;
  localparam int unsigned ALIGN_LSB   = 28;  // config fields are 256 MiB aligned
  localparam int unsigned GRAN_LSB    = 8;   // smallest granule is 256 bytes
  localparam int unsigned MAX_IW_ENC  = 4;   // up to 16 ways

  function automatic logic ways_enc_ok(input logic [7:0] enc);
    return enc <= 8'(MAX_IW_ENC);
  endfunction
endpackage

// File: rtl/hpa_dec_slot.sv
module hpa_dec_slot
  import hpa_dpa_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IG_W   = 4,
  parameter int unsigned IW_W   = 4
) (
  input  logic [ADDR_W-1:0] hpa_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic [ADDR_W-1:0] skip_i,
  input  logic [IG_W-1:0]   ig_i,
  input  logic [IW_W-1:0]   iw_i,
  output logic [ADDR_W-1:0] skip_o,
  output logic [ADDR_W-1:0] share_o,
  output logic [ADDR_W-1:0] xlat_o,
  output logic              in_range_o,
  output logic              ways_ok_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK =
    {{(ADDR_W-ALIGN_LSB){1'b1}}, {ALIGN_LSB{1'b0}}};

  logic [ADDR_W-1:0] base_a, size_a, off;
  logic [ADDR_W-1:0] keep_mask, lo_part, hi_part;
  int unsigned       lo_w, cut_w;

  assign base_a = base_i & ALIGN_MASK;
  assign size_a = size_i & ALIGN_MASK;
  assign skip_o = skip_i & ALIGN_MASK;
  assign off    = hpa_i - base_a;

  assign ways_ok_o  = ways_enc_ok(8'(iw_i));
  assign in_range_o = (hpa_i >= base_a) && (off < size_a);
  assign share_o    = ways_ok_o ? (size_a >> iw_i) : '0;

  always_comb begin
    lo_w      = GRAN_LSB + 32'(ig_i);
    cut_w     = lo_w + 32'(iw_i);
    keep_mask = ({ADDR_W{1'b1}} << lo_w);
    lo_part   = off & ~keep_mask;
    hi_part   = (off >> cut_w) << lo_w;
    xlat_o    = lo_part | hi_part;
  end
endmodule

// File: rtl/hpa_dec_walk.sv
module hpa_dec_walk #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned NUM_DEC = 4
) (
  input  logic [NUM_DEC-1:0][ADDR_W-1:0] skip_i,
  input  logic [NUM_DEC-1:0][ADDR_W-1:0] share_i,
  input  logic [NUM_DEC-1:0][ADDR_W-1:0] xlat_i,
  input  logic [NUM_DEC-1:0]             in_range_i,
  input  logic [NUM_DEC-1:0]             ways_ok_i,
  input  logic [NUM_DEC-1:0]             commit_i,
  output logic                           hit_o,
  output logic [ADDR_W-1:0]              dpa_o
);
  logic [ADDR_W-1:0] acc;
  logic              done;

  always_comb begin
    acc   = '0;
    done  = 1'b0;
    hit_o = 1'b0;
    dpa_o = '0;
    for (int i = 0; i < NUM_DEC; i++) begin
      if (!done) begin
        acc = acc + skip_i[i];
        if (!commit_i[i] || !ways_ok_i[i]) begin
          done = 1'b1;  // broken decoder on the path: miss
        end else if (in_range_i[i]) begin
          hit_o = 1'b1;
          dpa_o = acc + xlat_i[i];
          done  = 1'b1;
        end else begin
          acc = acc + share_i[i];
        end
      end
    end
  end
endmodule

// File: rtl/hpa_dpa_xlate.sv
module hpa_dpa_xlate
  import hpa_dpa_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned NUM_DEC = 4,
  parameter int unsigned IG_W    = 4,
  parameter int unsigned IW_W    = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic [ADDR_W-1:0]              hpa_i,
  input  logic [NUM_DEC-1:0][ADDR_W-1:0] dec_base_i,
  input  logic [NUM_DEC-1:0][ADDR_W-1:0] dec_size_i,
  input  logic [NUM_DEC-1:0][ADDR_W-1:0] dec_skip_i,
  input  logic [NUM_DEC-1:0][IG_W-1:0]   dec_ig_i,
  input  logic [NUM_DEC-1:0][IW_W-1:0]   dec_iw_i,
  input  logic [NUM_DEC-1:0]             dec_commit_i,
  output logic                           vld_o,
  output logic                           hit_o,
  output logic [ADDR_W-1:0]              dpa_o
);
  logic [NUM_DEC-1:0][ADDR_W-1:0] skip_w, share_w, xlat_w;
  logic [NUM_DEC-1:0]             in_range_w, ways_ok_w;
  logic                           hit_c;
  logic [ADDR_W-1:0]              dpa_c;

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_slot
    hpa_dec_slot #(.ADDR_W(ADDR_W), .IG_W(IG_W), .IW_W(IW_W)) i_slot (
      .hpa_i      (hpa_i),
      .base_i     (dec_base_i[g]),
      .size_i     (dec_size_i[g]),
      .skip_i     (dec_skip_i[g]),
      .ig_i       (dec_ig_i[g]),
      .iw_i       (dec_iw_i[g]),
      .skip_o     (skip_w[g]),
      .share_o    (share_w[g]),
      .xlat_o     (xlat_w[g]),
      .in_range_o (in_range_w[g]),
      .ways_ok_o  (ways_ok_w[g])
    );
  end

  hpa_dec_walk #(.ADDR_W(ADDR_W), .NUM_DEC(NUM_DEC)) i_walk (
    .skip_i     (skip_w),
    .share_i    (share_w),
    .xlat_i     (xlat_w),
    .in_range_i (in_range_w),
    .ways_ok_i  (ways_ok_w),
    .commit_i   (dec_commit_i),
    .hit_o      (hit_c),
    .dpa_o      (dpa_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      hit_o <= 1'b0;
      dpa_o <= '0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        hit_o <= hit_c;
        dpa_o <= hit_c ? dpa_c : '0;
      end
    end
  end

  AST_VLD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);  // R1
  AST_NO_STRAY_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o);  // R1
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> dpa_o == '0);  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(hit_o) && $stable(dpa_o));  // R10
  AST_UNCOMMITTED_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !dec_commit_i[0] |=> !hit_o);  // R5
  AST_BAD_WAYS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (dec_iw_i[0] > IW_W'(MAX_IW_ENC)) |=> !hit_o);  // R8
endmodule

// File: tb/test_hpa_dpa_xlate.sv
module test_hpa_dpa_xlate;
  localparam int AW = 64;
  localparam int ND = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] hpa = '0;
  logic [ND-1:0][AW-1:0] dbase, dsize, dskip;
  logic [ND-1:0][3:0] dig, diw;
  logic [ND-1:0] dcom;
  logic vld, hit;
  logic [AW-1:0] dpa;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  bit exp_vld = 0, exp_hit = 0;
  longint unsigned exp_dpa = 0;

  always #4 clk = ~clk;

  hpa_dpa_xlate i_hpa_dpa_xlate (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .hpa_i(hpa),
    .dec_base_i(dbase), .dec_size_i(dsize), .dec_skip_i(dskip),
    .dec_ig_i(dig), .dec_iw_i(diw), .dec_commit_i(dcom),
    .vld_o(vld), .hit_o(hit), .dpa_o(dpa)
  );

  // behavioural reference of the walk
  task automatic model(input longint unsigned a, output bit h, output longint unsigned d);
    longint unsigned run, b, s, k, off, g, ways;
    run = 0; h = 0; d = 0;
    for (int i = 0; i < ND; i++) begin
      b = dbase[i] / 64'h1000_0000 * 64'h1000_0000;
      s = dsize[i] / 64'h1000_0000 * 64'h1000_0000;
      k = dskip[i] / 64'h1000_0000 * 64'h1000_0000;
      run = run + k;
      if (!dcom[i] || diw[i] > 4) return;
      ways = 64'd1 << diw[i];
      if (a >= b && (a - b) < s) begin
        off = a - b;
        g = 64'd256 << dig[i];
        d = run + (off % g) + (off / (g * ways)) * g;
        h = 1;
        return;
      end
      run = run + s / ways;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_vld = 0; exp_hit = 0; exp_dpa = 0;
    end else begin
      exp_vld = req;
      if (req) model(hpa, exp_hit, exp_dpa);
    end
  end

  task automatic cyc();
    @(negedge clk);
    checks++;
    if (vld !== exp_vld || hit !== exp_hit || dpa !== exp_dpa) begin
      errors++;
      $display("FAIL %s: vld/hit/dpa actual %b/%b/%h expected %b/%b/%h",
               tag, vld, hit, dpa, exp_vld, exp_hit, exp_dpa);
    end
  endtask

  task automatic xlate(input string t, input longint unsigned a);
    tag = t; hpa = a; req = 1'b1;
    cyc();
    req = 1'b0; hpa = ~a;
    cyc();
  endtask

  task automatic base_cfg();
    dbase[0] = 64'h1_0000_0000; dsize[0] = 64'h4000_0000; dskip[0] = 0;
    dig[0] = 0; diw[0] = 0;
    dbase[1] = 64'h2_0000_0000; dsize[1] = 64'h8000_0000; dskip[1] = 64'h1000_0000;
    dig[1] = 1; diw[1] = 1;
    dbase[2] = 64'h4_0000_0000; dsize[2] = 64'h4000_0000; dskip[2] = 0;
    dig[2] = 2; diw[2] = 2;
    dbase[3] = 64'h8_0000_0000; dsize[3] = 64'h1000_0000; dskip[3] = 64'h2000_0000;
    dig[3] = 0; diw[3] = 0;
    dcom = '1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    base_cfg();
    tag = "R1";
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    xlate("R1", 64'h1_0000_1234);
    xlate("R6", 64'h1_3FFF_FFFF);
    xlate("R6", 64'h1_4000_0000);
    xlate("R6", 64'h0_FFFF_FFFF);
    xlate("R7", 64'h2_1234_5678);
    xlate("R7", 64'h2_7FFF_FFFF);
    xlate("R4", 64'h4_0ABC_DEF1);
    xlate("R4", 64'h8_0FFF_FFF0);
    xlate("R9", 64'h9_0000_0000);
    xlate("R9", 64'h0);
    // low config bits must not matter
    dbase[1] = 64'h2_0FFF_FFFF; dsize[1] = 64'h8FFF_FFFF; dskip[1] = 64'h1FFF_FFFF;
    xlate("R2", 64'h2_0000_0010);
    xlate("R2", 64'h2_8000_0000);
    base_cfg();
    // overlap: decoder 0 wins
    dbase[3] = 64'h1_0000_0000; dsize[3] = 64'h4000_0000;
    xlate("R3", 64'h1_2000_0040);
    base_cfg();
    dcom[2] = 0;
    xlate("R3", 64'h2_0000_0300);
    xlate("R5", 64'h8_0000_0100);
    dcom = '1; dcom[0] = 0;
    xlate("R5", 64'h1_0000_0000);
    xlate("R5", 64'h2_0000_0000);
    base_cfg();
    diw[1] = 5;
    xlate("R8", 64'h1_0000_0800);
    xlate("R8", 64'h4_0000_0000);
    diw[1] = 4; dig[1] = 3;
    xlate("R8", 64'h2_3456_789A);
    xlate("R7", 64'h4_0000_0000);
    base_cfg();
    // idle cycles with changing inputs
    xlate("R10", 64'h2_0000_1000);
    tag = "R10";
    for (int i = 0; i < 6; i++) begin
      hpa = {$urandom, $urandom}; dcom = 4'($urandom); diw[0] = 4'($urandom);
      cyc();
    end
    base_cfg();
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < ND; i++) begin
        dig[i] = 4'($urandom_range(0, 6));
        diw[i] = 4'($urandom_range(0, 4));
      end
      if (n % 10 == 0) diw[$urandom_range(0, 3)] = 4'($urandom_range(5, 15));
      xlate("R4", {28'd0, 4'($urandom_range(0, 9)), 32'($urandom)});
    end
    tag = "R1";
    rst_n = 1'b0;
    cyc();
    rst_n = 1'b1;
    cyc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule